// File: doc/BRIEF.md
# Serial Input Edge Event Detector

This block sits behind the shift engine of a serial GPIO link. Once per scan, the shift engine delivers a fresh snapshot of up to 64 input pins. The block compares that snapshot with the one from the previous scan. For every pin, a two-bit field chooses rising edges, falling edges, both, or neither. A pin that moves in an enabled direction latches a bit in its port's status byte. A single interrupt line stays high while any latched bit remains.

Software programs one 16-bit configuration word for each 8-pin port. It reads the status bytes and clears them by writing ones. Pin `k` of port `p` is carried on `scan_data[p*8 + k]`. When detection is switched on, the first snapshot after that only sets the reference. Edges are reported from the second snapshot onwards.

Top module: `sgpio_evt_det`

## Requirements
- R1: After reset, every configuration word and every status bit is 0, `irq` is 0 and `reg_rdata` is 0.
- R2: The configuration word of port p (16 bits) is written and read at address 0x10 + 2*p (ports 0..7). A write stores all 16 bits, and a read in the next cycle returns them on `reg_rdata`.
- R3: The field of pin k occupies bits [2k+1:2k] of its port's word. When bit 2k is 1, a scan whose sample of that pin is 1 sets status bit k of the port, provided the previous scan had sampled 0.
- R4: When bit 2k+1 is 1, a scan whose sample of the pin is 0 sets status bit k, provided the previous scan had sampled 1.
- R5: A field of 11 sets the status bit on either edge. A field of 01 ignores falling edges.
- R6: A field of 00 never sets the status bit, whatever the pin does.
- R7: While `det_en` is 0 no status bit is set. The first scan after `det_en` returns to 1 only records the reference.
- R8: Status byte p is read at address 0x20 + p (bits [7:0], upper bits 0). Writing it clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R9: If a scan sets a status bit on the same cycle that a write clears it, the bit ends up set.
- R10: `irq` is 1 exactly while at least one status bit is set. It changes on the same clock edge as the status.
- R11: Edges are judged only between successive scans (`scan_valid` = 1). A change of `scan_data` between scans does not count.
- R12: Reads of unmapped addresses return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| det_en | input | 1 | Detection enable. While low, the reference is dropped |
| scan_valid | input | 1 | One-cycle pulse: `scan_data` holds a new snapshot |
| scan_data | input | 64 | Snapshot, pin k of port p on bit p*8+k |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte address |
| reg_wdata | input | 16 | Write data (status writes use bits [7:0]) |
| reg_rdata | output | 16 | Registered read data for the address of the previous cycle |
| irq | output | 1 | Combined event interrupt, registered |

## Verification
A wrong reference register shows up as spurious or missing status bits, and therefore as `irq` on the very edge that ends the faulty scan. The directed tests flip one pin at a time around that scan and read the status straight back. A fault in the clear path or in the set-over-clear priority is visible one read later as a status byte that differs from the expected one. A wrong address decode shows up as a read-back mismatch in the cycle after the read.

// File: rtl/sgpio_evt_pkg.sv
package sgpio_evt_pkg;
  // Two-bit edge selection field, one per input pin
  localparam int FIELD_W = 2;
  localparam int RISE_BIT = 0;
  localparam int FALL_BIT = 1;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_CFG  = 2'd1,
    ACC_STS  = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/sgpio_evt_cfg.sv
module sgpio_evt_cfg #(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 8,
  parameter int PIDX_W    = 3,
  localparam int NPIN     = NUM_PORTS * PORT_W,
  localparam int CFG_W    = sgpio_evt_pkg::FIELD_W * PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [PIDX_W-1:0] wr_port,
  input  logic [CFG_W-1:0]  wr_data,
  input  logic [PIDX_W-1:0] rd_port,
  output logic [CFG_W-1:0]  rd_data,
  output logic [NPIN-1:0]   rise_en,
  output logic [NPIN-1:0]   fall_en
);
  import sgpio_evt_pkg::*;

  logic [CFG_W-1:0] cfg_q [NUM_PORTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int p = 0; p < NUM_PORTS; p++) cfg_q[p] <= '0;
    end else if (wr_en) begin
      cfg_q[wr_port] <= wr_data;
    end
  end

  assign rd_data = cfg_q[rd_port];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    for (genvar k = 0; k < PORT_W; k++) begin : g_pin
      assign rise_en[p*PORT_W + k] = cfg_q[p][k*FIELD_W + RISE_BIT];
      assign fall_en[p*PORT_W + k] = cfg_q[p][k*FIELD_W + FALL_BIT];
    end
  end
endmodule

// File: rtl/sgpio_evt_edge.sv
module sgpio_evt_edge #(
  parameter int NPIN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            det_en,
  input  logic            scan_valid,
  input  logic [NPIN-1:0] scan_data,
  input  logic [NPIN-1:0] rise_en,
  input  logic [NPIN-1:0] fall_en,
  output logic [NPIN-1:0] hits,
  output logic            ref_valid
);
  logic [NPIN-1:0] prev_q;
  logic            ref_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      ref_q  <= 1'b0;
    end else begin
      if (scan_valid) prev_q <= scan_data;
      if (!det_en)         ref_q <= 1'b0;
      else if (scan_valid) ref_q <= 1'b1;
    end
  end

  always_comb begin
    hits = '0;
    if (scan_valid && det_en && ref_q)
      hits = (rise_en & ~prev_q & scan_data) | (fall_en & prev_q & ~scan_data);
  end

  assign ref_valid = ref_q;
endmodule

// File: rtl/sgpio_evt_status.sv
module sgpio_evt_status #(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 8,
  parameter int PIDX_W    = 3,
  localparam int NPIN     = NUM_PORTS * PORT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPIN-1:0]   hits,
  input  logic              clr_en,
  input  logic [PIDX_W-1:0] clr_port,
  input  logic [PORT_W-1:0] clr_mask,
  input  logic [PIDX_W-1:0] rd_port,
  output logic [PORT_W-1:0] rd_data,
  output logic [NPIN-1:0]   sts,
  output logic              irq
);
  logic [NPIN-1:0] sts_q, sts_n, clr_vec;
  logic            irq_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_clr
    assign clr_vec[p*PORT_W +: PORT_W] =
      (clr_en && clr_port == PIDX_W'(p)) ? clr_mask : '0;
  end

  // a fresh event outranks a clear landing on the same edge
  assign sts_n = (sts_q & ~clr_vec) | hits;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      irq_q <= 1'b0;
    end else begin
      sts_q <= sts_n;
      irq_q <= |sts_n;
    end
  end

  assign rd_data = sts_q[rd_port*PORT_W +: PORT_W];
  assign sts     = sts_q;
  assign irq     = irq_q;
endmodule

// File: rtl/sgpio_evt_det.sv
module sgpio_evt_det #(
  parameter int NUM_PORTS = 8,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 6,
  parameter int CFG_BASE  = 16,
  parameter int STS_BASE  = 32,
  localparam int NPIN     = NUM_PORTS * PORT_W,
  localparam int DATA_W   = sgpio_evt_pkg::FIELD_W * PORT_W,
  localparam int PIDX_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              det_en,
  input  logic              scan_valid,
  input  logic [NPIN-1:0]   scan_data,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  import sgpio_evt_pkg::*;

  acc_kind_e         acc;
  logic [PIDX_W-1:0] acc_port;
  logic [ADDR_W-1:0] cfg_off, sts_off;

  assign cfg_off = reg_addr - ADDR_W'(CFG_BASE);
  assign sts_off = reg_addr - ADDR_W'(STS_BASE);

  always_comb begin
    acc      = ACC_NONE;
    acc_port = '0;
    if (reg_addr >= ADDR_W'(CFG_BASE) && !cfg_off[0] &&
        (cfg_off >> 1) < ADDR_W'(NUM_PORTS)) begin
      acc      = ACC_CFG;
      acc_port = PIDX_W'(cfg_off >> 1);
    end else if (reg_addr >= ADDR_W'(STS_BASE) &&
                 sts_off < ADDR_W'(NUM_PORTS)) begin
      acc      = ACC_STS;
      acc_port = PIDX_W'(sts_off);
    end
  end

  logic [DATA_W-1:0] cfg_rd;
  logic [PORT_W-1:0] sts_rd;
  logic [NPIN-1:0]   rise_en, fall_en, hits, sts_flat;
  logic              ref_valid;
  logic [DATA_W-1:0] rdata_q;

  sgpio_evt_cfg #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .PIDX_W(PIDX_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_we && acc == ACC_CFG),
    .wr_port (acc_port),
    .wr_data (reg_wdata),
    .rd_port (acc_port),
    .rd_data (cfg_rd),
    .rise_en (rise_en),
    .fall_en (fall_en)
  );

  sgpio_evt_edge #(.NPIN(NPIN)) u_edge (
    .clk        (clk),
    .rst        (rst),
    .det_en     (det_en),
    .scan_valid (scan_valid),
    .scan_data  (scan_data),
    .rise_en    (rise_en),
    .fall_en    (fall_en),
    .hits       (hits),
    .ref_valid  (ref_valid)
  );

  sgpio_evt_status #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .PIDX_W(PIDX_W)) u_sts (
    .clk      (clk),
    .rst      (rst),
    .hits     (hits),
    .clr_en   (reg_we && acc == ACC_STS),
    .clr_port (acc_port),
    .clr_mask (reg_wdata[PORT_W-1:0]),
    .rd_port  (acc_port),
    .rd_data  (sts_rd),
    .sts      (sts_flat),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (acc)
        ACC_CFG: rdata_q <= cfg_rd;
        ACC_STS: rdata_q <= DATA_W'(sts_rd);
        default: rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
endmodule

// File: rtl/sgpio_evt_chk.sv
module sgpio_evt_chk #(
  parameter int NPIN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            scan_valid,
  input logic            ref_valid,
  input logic [NPIN-1:0] hits,
  input logic [NPIN-1:0] sts,
  input logic            irq
);
  AST_REF_ONLY_SCAN: assert property (@(posedge clk) disable iff (rst)
    !ref_valid |=> ((sts & ~$past(sts)) == '0)); // R7

  AST_NO_SET_BETWEEN_SCANS: assert property (@(posedge clk) disable iff (rst)
    !scan_valid |=> ((sts & ~$past(sts)) == '0)); // R11

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (hits != '0) |=> ((sts & $past(hits)) == $past(hits))); // R9

  AST_IRQ_RISE_ON_SCAN: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(scan_valid)); // R10

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq |-> (sts != '0)); // R10
endmodule

bind sgpio_evt_det sgpio_evt_chk #(.NPIN(NPIN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .scan_valid (scan_valid),
  .ref_valid  (ref_valid),
  .hits       (hits),
  .sts        (sts_flat),
  .irq        (irq)
);

// File: tb/sim_sgpio_evt_det.sv
module sim_sgpio_evt_det;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] B19 = 64'd1 << 19;  // port 2 pin 3
  localparam logic [63:0] B40 = 64'd1 << 40;  // port 5 pin 0
  localparam logic [63:0] B63 = 64'd1 << 63;  // port 7 pin 7

  logic        clk = 1'b0, rst = 1'b1, det_en = 1'b0, scan_valid = 1'b0, reg_we = 1'b0;
  logic [63:0] scan_data = '0;
  logic [5:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic        irq;
  int          n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sgpio_evt_det u0 (.clk(clk), .rst(rst), .det_en(det_en), .scan_valid(scan_valid),
    .scan_data(scan_data), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] cfg_a(input int p); return 6'(16 + 2*p); endfunction
  function automatic logic [5:0] sts_a(input int p); return 6'(32 + p); endfunction

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic scan(input logic [63:0] d);
    @(negedge clk); scan_data = d; scan_valid = 1'b1;
    @(negedge clk); scan_valid = 1'b0;
  endtask

  task automatic chk_sts(input string tag, input int p, input logic [7:0] exp);
    logic [15:0] v;
    rd(sts_a(p), v);
    chk(tag, v, {8'h00, exp});
  endtask

  task automatic clr_all();
    for (int p = 0; p < 8; p++) wr(sts_a(p), 16'h00FF);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 irq after reset", irq, 0);
    chk("R1 rdata after reset", reg_rdata, 0);
    for (int p = 0; p < 8; p++) begin
      rd(cfg_a(p), v); chk("R1 cfg zero", v, 0);
      rd(sts_a(p), v); chk("R1 sts zero", v, 0);
    end
  endtask

  task automatic t_cfg_rw();
    logic [15:0] v;
    for (int p = 0; p < 8; p++) wr(cfg_a(p), 16'hA5A5 ^ 16'(p * 16'h0301));
    for (int p = 0; p < 8; p++) begin
      rd(cfg_a(p), v); chk("R2 cfg readback", v, 16'hA5A5 ^ 16'(p * 16'h0301));
    end
    for (int p = 0; p < 8; p++) wr(cfg_a(p), 16'h0000);
  endtask

  task automatic t_rise();
    wr(cfg_a(2), 16'h0040);
    scan(B19 | (64'd1 << 20));
    chk("R3 irq on rise", irq, 1);
    chk_sts("R3 rise sets pin3 only", 2, 8'h08);
    clr_all();
    chk("R10 irq drops after clear", irq, 0);
    scan(64'd0);
    chk("R5 rise-only ignores fall", irq, 0);
    chk_sts("R5 rise-only status", 2, 8'h00);
  endtask

  task automatic t_fall();
    wr(cfg_a(5), 16'h0002);
    scan(B40);
    chk_sts("R4 rise ignored by fall field", 5, 8'h00);
    scan(64'd0);
    chk("R4 irq on fall", irq, 1);
    chk_sts("R4 fall sets pin0", 5, 8'h01);
    clr_all();
  endtask

  task automatic t_both();
    wr(cfg_a(7), 16'hC000);
    scan(B63);
    chk_sts("R5 both: rise", 7, 8'h80);
    clr_all();
    chk_sts("R5 both: cleared", 7, 8'h00);
    scan(64'd0);
    chk_sts("R5 both: fall", 7, 8'h80);
    clr_all();
  endtask

  task automatic t_w1c();
    scan(B19 | B63);
    chk_sts("R8 setup p2", 2, 8'h08);
    wr(sts_a(2), 16'h0000);
    chk_sts("R8 zero write keeps", 2, 8'h08);
    wr(sts_a(2), 16'h00F7);
    chk_sts("R8 other ones keep bit", 2, 8'h08);
    wr(sts_a(2), 16'h0008);
    chk_sts("R8 one clears", 2, 8'h00);
    chk("R10 irq held by p7", irq, 1);
    wr(sts_a(7), 16'h0080);
    chk("R10 irq low when all clear", irq, 0);
    scan(64'd0);
    chk_sts("R8 p7 fall after clear", 7, 8'h80);
    clr_all();
  endtask

  task automatic t_disabled();
    wr(cfg_a(0), 16'h0000);
    scan(64'h00FF);
    scan(64'h0000);
    chk("R6 irq with zero field", irq, 0);
    chk_sts("R6 p0 stays clear", 0, 8'h00);
    wr(cfg_a(2), 16'h0000);
    scan(B19);
    chk_sts("R6 p2 field zeroed", 2, 8'h00);
    scan(64'd0);
    wr(cfg_a(2), 16'h0040);
  endtask

  task automatic t_between_scans();
    @(negedge clk); scan_data = B19;
    repeat (3) @(negedge clk);
    scan(64'd0);
    chk("R11 no irq between scans", irq, 0);
    chk_sts("R11 glitch ignored", 2, 8'h00);
  endtask

  task automatic t_ref();
    @(negedge clk); det_en = 1'b0;
    scan(B19);
    chk("R7 disabled no irq", irq, 0);
    chk_sts("R7 disabled no status", 2, 8'h00);
    @(negedge clk); det_en = 1'b1;
    scan(B63);
    chk("R7 reference scan quiet", irq, 0);
    chk_sts("R7 reference scan p7", 7, 8'h00);
    scan(B63 | B19);
    chk_sts("R7 second scan detects p2", 2, 8'h08);
    chk_sts("R7 second scan p7 steady", 7, 8'h00);
    clr_all();
    scan(64'd0);
    chk_sts("R7 p7 fall after reference", 7, 8'h80);
    clr_all();
  endtask

  task automatic t_set_wins();
    @(negedge clk);
    scan_data = B19; scan_valid = 1'b1;
    reg_we = 1'b1; reg_addr = sts_a(2); reg_wdata = 16'h0008;
    @(negedge clk); scan_valid = 1'b0; reg_we = 1'b0;
    chk("R9 irq set wins", irq, 1);
    chk_sts("R9 set beats clear", 2, 8'h08);
    clr_all();
    scan(64'd0);
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    wr(6'h11, 16'hFFFF);
    rd(cfg_a(0), v); chk("R12 odd write ignored", v, 16'h0000);
    rd(6'h11, v);    chk("R12 odd read zero", v, 16'h0000);
    rd(6'h30, v);    chk("R12 high read zero", v, 16'h0000);
    rd(6'h28, v);    chk("R12 past status zero", v, 16'h0000);
    rd(cfg_a(7), v); chk("R2 port7 cfg address", v, 16'hC000);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_cfg_rw();
    @(negedge clk); det_en = 1'b1;
    scan(64'd0);
    t_rise();
    t_fall();
    t_both();
    t_w1c();
    t_disabled();
    t_between_scans();
    t_ref();
    t_set_wins();
    t_unmapped();
    report();
  end
endmodule